// File: doc/BRIEF.md
# Step Attenuator Serial Programming Master

This block sits on the host side of a 4-bit step attenuator that is programmed over a three-wire serial port (data, clock and latch enable). A client hands over a 4-bit attenuation code through a valid/ready handshake. The block then wraps the code in a 6-bit frame, with a zero bit ahead of the code and a zero bit after it, and shifts the frame out most significant bit first. The attenuator's latch enable stays low while the bits go out. The block then raises latch enable for one pulse, and the receiver loads the new code.

Each timing constraint of the port is a parameter counted in system-clock cycles. These are the clock high and low times, the data setup before a rising clock edge, the data hold after a falling clock edge, the delay from the last falling clock edge to latch enable, and the latch enable pulse width. A further parameter sets the minimum spacing between two accepted requests, which keeps the update rate within the attenuator's switching limit. The serial clock idles low. Data moves only while the clock is low.

Top module: `atten_serial_master`

## Requirements
- R1: While reset is held and on leaving reset, ser_clk, ser_data and ser_le are 0 and req_ready is 1.
- R2: Each accepted request produces exactly 6 rising edges of ser_clk. At those edges ser_data carries, in order: 0, code bit 3, code bit 2, code bit 1, code bit 0, 0.
- R3: ser_le is 0 at every rising edge of ser_clk and is never high together with ser_clk. It rises exactly once per request, after the sixth rising edge.
- R4: ser_clk stays high for at least CLK_HI cycles. Between a falling edge and the next rising edge it stays low for at least CLK_LO cycles.
- R5: ser_data is stable for at least DSU cycles before each rising edge of ser_clk. It does not change while ser_clk is high, nor within DHLD cycles after a falling edge.
- R6: ser_le rises no sooner than LE_SU cycles after the last falling edge of ser_clk and stays high for at least LE_PW cycles.
- R7: req_ready goes low in the cycle after a request is accepted. It stays low until at least GAP cycles have passed since that acceptance, so two acceptances are never closer than GAP cycles.
- R8: While req_ready is low, req_valid and req_code are ignored. They start no frame and do not alter the frame in flight.
- R9: After the latch enable pulse, a receiving 6-bit shift register with a transparent latch holds the requested code in its four middle bits, for every code 0 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_code | input | CODE_W | Attenuation code, 1 dB per LSB |
| req_ready | output | 1 | Block can accept a request |
| ser_clk | output | 1 | Serial clock to the attenuator, idles low |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_le | output | 1 | Latch enable to the attenuator |

## Verification
The bench builds the block with CLK_HI and CLK_LO of 6 cycles, DSU, DHLD and LE_SU of 2 cycles, LE_PW of 6 cycles and GAP of 400 cycles. At 200 MHz these values meet the port's 30 ns and 10 ns minimums with no slack, so a stage that ends one cycle early shows up at once in the bench's edge-to-edge measurements. The spacing is cut to 400 cycles from the 8000 a 25 kHz limit would need. That makes room for all sixteen codes, back-to-back requests that push on the spacing rule, and requests made while the block is busy.

// File: rtl/atten_serial_master.sv
module atten_serial_master #(
  parameter int CODE_W = 4,
  parameter int CLK_HI = 10,
  parameter int CLK_LO = 10,
  parameter int DSU    = 2,
  parameter int DHLD   = 2,
  parameter int LE_SU  = 2,
  parameter int LE_PW  = 6,
  parameter int GAP    = 8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  output logic              req_ready,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_le
);

  localparam int FRM_W  = CODE_W + 2;
  localparam int SU_N   = (DSU > CLK_LO - DHLD) ? DSU : CLK_LO - DHLD;
  localparam int TAIL_N = (DHLD > LE_SU) ? DHLD : LE_SU;
  localparam int CW     = $clog2(GAP + CLK_HI + CLK_LO + DSU + DHLD + LE_SU + LE_PW + 1);
  localparam int BW     = $clog2(FRM_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_HOLD, ST_TAIL, ST_LATCH, ST_GAP
  } st_t;

  st_t             st, nst;
  logic [CW-1:0]   cnt, ncnt, gcnt;
  logic [FRM_W-1:0] frm, nfrm;
  logic [BW-1:0]   bitn, nbit;
  logic            accept;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    nst  = st;
    ncnt = (cnt != '0) ? cnt - 1'b1 : '0;
    nfrm = frm;
    nbit = bitn;
    case (st)
      ST_IDLE: if (req_valid) begin
        nst  = ST_SETUP;
        ncnt = CW'(SU_N - 1);
        nfrm = {1'b0, req_code, 1'b0};
        nbit = BW'(FRM_W - 1);
      end
      ST_SETUP: if (cnt == '0) begin
        nst  = ST_HIGH;
        ncnt = CW'(CLK_HI - 1);
      end
      ST_HIGH: if (cnt == '0) begin
        if (bitn == '0) begin
          nst  = ST_TAIL;
          ncnt = CW'(TAIL_N - 1);
        end else begin
          nst  = ST_HOLD;
          ncnt = CW'(DHLD - 1);
        end
      end
      ST_HOLD: if (cnt == '0) begin
        nst  = ST_SETUP;
        ncnt = CW'(SU_N - 1);
        nfrm = {frm[FRM_W-2:0], 1'b0};
        nbit = bitn - 1'b1;
      end
      ST_TAIL: if (cnt == '0) begin
        nst  = ST_LATCH;
        ncnt = CW'(LE_PW - 1);
      end
      ST_LATCH: if (cnt == '0) nst = ST_GAP;
      ST_GAP:   if (gcnt == '0) nst = ST_IDLE;
      default:  nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      gcnt     <= '0;
      frm      <= '0;
      bitn     <= '0;
      ser_clk  <= 1'b0;
      ser_data <= 1'b0;
      ser_le   <= 1'b0;
    end else begin
      st       <= nst;
      cnt      <= ncnt;
      frm      <= nfrm;
      bitn     <= nbit;
      ser_clk  <= (nst == ST_HIGH);
      ser_le   <= (nst == ST_LATCH);
      ser_data <= nfrm[FRM_W-1];
      if (accept)            gcnt <= CW'(GAP - 1);
      else if (gcnt != '0)   gcnt <= gcnt - 1'b1;
    end
  end

endmodule

// File: rtl/atten_serial_master_chk.sv
module atten_serial_master_chk #(
  parameter int CLK_HI = 10,
  parameter int LE_PW  = 6,
  parameter int GAP    = 8000
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_le
);

  localparam int CW = $clog2(GAP + CLK_HI + LE_PW + 2);

  logic [CW-1:0] hi_run, le_run, since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      le_run <= '0;
      since  <= CW'(GAP);
    end else begin
      hi_run <= ser_clk ? hi_run + 1'b1 : '0;
      le_run <= ser_le  ? le_run + 1'b1 : '0;
      if (req_valid && req_ready) since <= CW'(1);
      else if (since < CW'(GAP))  since <= since + 1'b1;
    end
  end

  p_le_low_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> !ser_le);

  p_clk_le_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && ser_le));

  p_high_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> hi_run >= CW'(CLK_HI));

  p_data_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  p_le_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_le) |-> le_run >= CW'(LE_PW));

  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> since >= CW'(GAP));

endmodule

bind atten_serial_master atten_serial_master_chk #(
  .CLK_HI(CLK_HI), .LE_PW(LE_PW), .GAP(GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le)
);

// File: tb/sim_atten_serial_master.sv
`timescale 1ns/1ps
module sim_atten_serial_master;
  localparam int CLK_HI = 6, CLK_LO = 6, DSU = 2, DHLD = 2, LE_SU = 2, LE_PW = 6, GAP = 400;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [3:0] req_code = '0;
  logic req_ready, ser_clk, ser_data, ser_le;

  always #2.5 clk = ~clk;

  atten_serial_master #(.CODE_W(4), .CLK_HI(CLK_HI), .CLK_LO(CLK_LO), .DSU(DSU),
    .DHLD(DHLD), .LE_SU(LE_SU), .LE_PW(LE_PW), .GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_ready(req_ready), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le));

  int checks = 0, errors = 0;
  int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0;
  int cyc = 0, nbits = 0, last_bits = 0, nlatch = 0, nacc = 0;
  int last_rise = -1000, last_fall = -1000, last_dchg = -1000, le_rise = -1000, acc_cyc = -100000;
  logic [5:0] sr = '0, held = '0;
  logic p_clk = 0, p_dat = 0, p_le = 0, p_acc = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // receiver model and timing monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ser_clk && !p_clk) begin
        if (ser_le) v_r3++;
        if (cyc - last_dchg < DSU) v_r5++;
        if (cyc - last_fall < CLK_LO) v_r4++;
        sr = {sr[4:0], ser_data};
        nbits++;
        last_rise = cyc;
      end
      if (!ser_clk && p_clk) begin
        if (cyc - last_rise < CLK_HI) v_r4++;
        last_fall = cyc;
      end
      if (ser_data != p_dat) begin
        if (ser_clk) v_r5++;
        if (cyc - last_fall < DHLD) v_r5++;
        last_dchg = cyc;
      end
      if (ser_clk && ser_le) v_r3++;
      if (ser_le && !p_le) begin
        if (cyc - last_fall < LE_SU) v_r6++;
        if (nbits != 6) v_r3++;
        le_rise = cyc;
      end
      if (ser_le) held = sr;
      if (!ser_le && p_le) begin
        if (cyc - le_rise < LE_PW) v_r6++;
        last_bits = nbits;
        nbits = 0;
        nlatch++;
      end
      if (p_acc && req_ready) v_r7++;
      if (req_ready && cyc - acc_cyc < GAP) v_r7++;
      p_acc = req_valid && req_ready;
      if (p_acc) begin
        if (cyc - acc_cyc < GAP) v_r7++;
        acc_cyc = cyc;
        nacc++;
      end
    end
    p_clk = ser_clk; p_dat = ser_data; p_le = ser_le;
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!ser_clk && !ser_data && !ser_le, "R1 outputs in reset", {ser_clk, ser_data, ser_le}, 0);
    check(req_ready, "R1 ready in reset", req_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!ser_clk && !ser_data && !ser_le && req_ready, "R1 after reset",
          {req_ready, ser_clk, ser_data, ser_le}, 8);
  endtask

  task automatic t_send(input logic [3:0] c);
    int n0 = nlatch;
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1'b1; req_code = c;
    @(posedge clk); #1 req_valid = 1'b0;
    wait (nlatch == n0 + 1);
    @(negedge clk);
    check(held[4:1] == c, "R9 latched code", held[4:1], c);
    check(held == {1'b0, c, 1'b0}, "R2 frame order", held, {1'b0, c, 1'b0});
    check(last_bits == 6, "R2 clock count", last_bits, 6);
  endtask

  task automatic t_timing(input string when);
    check(v_r3 == 0, {"R3 latch enable vs clock ", when}, v_r3, 0);
    check(v_r4 == 0, {"R4 clock high/low ", when}, v_r4, 0);
    check(v_r5 == 0, {"R5 setup/hold ", when}, v_r5, 0);
    check(v_r6 == 0, {"R6 latch delay/width ", when}, v_r6, 0);
    check(v_r7 == 0, {"R7 ready spacing ", when}, v_r7, 0);
  endtask

  task automatic t_all_codes();
    for (int c = 0; c < 16; c++) t_send(4'(c));
    t_timing("all codes");
  endtask

  task automatic t_back_to_back();
    int a0;
    t_send(4'hA);
    a0 = acc_cyc;
    t_send(4'h5);
    check(acc_cyc - a0 >= GAP, "R7 accept spacing", acc_cyc - a0, GAP);
    t_timing("back to back");
  endtask

  task automatic t_busy_ignore();
    int n0, a0;
    n0 = nlatch;
    a0 = nacc;
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1'b1; req_code = 4'h3;
    @(posedge clk); #1 req_code = 4'hC;
    repeat (30) @(posedge clk);
    #1 req_valid = 1'b0;
    wait (nlatch == n0 + 1);
    @(negedge clk);
    check(held[4:1] == 4'h3, "R8 frame in flight unchanged", held[4:1], 3);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    repeat (50) @(negedge clk);
    check(nlatch == n0 + 1, "R8 no extra frame", nlatch - n0, 1);
    check(nacc == a0 + 1, "R8 no extra accept", nacc - a0, 1);
    check(held[4:1] == 4'h3, "R8 receiver holds code", held[4:1], 3);
    t_timing("busy");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_all_codes();
    t_back_to_back();
    t_busy_ignore();
    t_send(4'hF);
    t_send(4'h0);
    t_timing("final");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule